// File: doc/BRIEF.md
# Transmit Payload Serializer

This block sends the payload section of an outgoing radio packet, the part that sits between the sync word and the CRC. On a start pulse it reads payload bytes from a byte-wide packet memory. The first read is at a programmable base address, and each later read is at the next address, wrapping at the end of the memory. Each byte is shifted out one bit per bit strobe. A per-packet setting chooses whether the most or the least significant bit of each byte goes first.

The number of bytes comes from one of two places. In fixed mode it is a length input. In variable mode it is the first payload byte in memory. That length byte is itself sent as the first payload byte and is included in the count. The memory read port has a latency of one cycle. The block reads the following byte while the current one is still shifting, so consecutive bytes go out with no idle bit periods between them. A single-cycle done pulse ends every packet. A packet of zero length also ends with a done pulse, and no bits are sent.

Top module: `pkt_payload_ser`

## Requirements
- R1: In the cycle after an accepted start pulse, the block asserts `mem_rd_o` with `mem_addr_o` equal to `base_addr_i` as sampled at the start pulse (except for a fixed-mode length of zero).
- R2: With `lsb_first_i` = 0, bit k (k = 0..7) sent for a byte is bit 7-k of that byte.
- R3: With `lsb_first_i` = 1, bit k sent for a byte is bit k of that byte.
- R4: With `var_len_i` = 0 and `max_len_i` = N > 0, exactly N bytes (8N strobed bits) are sent.
- R5: With `var_len_i` = 1, the byte at the base address is the length L. It is sent as the first payload byte, and exactly L bytes are sent in total.
- R6: A length of zero sends no bits. In fixed mode, `done_o` is high in the cycle after start and there are no memory reads. In variable mode, `done_o` is high three cycles after start, after one read.
- R7: Successive reads step the address by one and wrap modulo `MEM_DEPTH`. A packet of N bytes makes exactly N reads.
- R8: When a strobe arrives on every cycle, `bit_vld_o` stays high with no gap from the first payload bit to the last.
- R9: `done_o` is a single-cycle pulse. It is high in the cycle after the strobe that takes the last bit, and `bit_vld_o` is low while it is high.
- R10: A start pulse while a packet is in progress is ignored. Bit strobes while idle have no effect.
- R11: After reset, `bit_vld_o`, `done_o` and `mem_rd_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| var_len_i | input | 1 | 1: length from the first payload byte; 0: length from `max_len_i` |
| lsb_first_i | input | 1 | 1: least significant bit first; 0: most significant bit first |
| base_addr_i | input | AW | Address of the first payload byte |
| max_len_i | input | LEN_W | Payload byte count in fixed mode |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read address |
| mem_data_i | input | 8 | Read data, valid one cycle after `mem_rd_o` |
| bit_stb_i | input | 1 | Bit strobe; consumes the current bit |
| bit_o | output | 1 | Current serial bit |
| bit_vld_o | output | 1 | `bit_o` holds a payload bit |
| done_o | output | 1 | Packet finished (one-cycle pulse) |

## Verification
An accepted start produces the first read one cycle later. The first payload bit appears on `bit_o` two cycles after that read, once the read data has been loaded. Each strobe moves to the next bit on the following edge, and `done_o` rises in the cycle after the last strobe. For zero lengths, done is due exactly one cycle after start in fixed mode and three cycles after start in variable mode. The bench drives its inputs and samples its outputs on the falling edge. It records each bit in the same half-cycle in which it raises the strobe for that bit, and checks the zero-length cases at those exact falling edges.

// File: rtl/pps_pkg.sv
package pps_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RD0   = 2'd1,
      ST_WT0   = 2'd2,
      ST_SHIFT = 2'd3
   } pps_state_e;
endpackage

// File: rtl/pps_addr_gen.sv
module pps_addr_gen #(
   parameter int DEPTH = 256,
   parameter int AW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] base_i,
   input  logic          inc_i,
   output logic [AW-1:0] addr_o
);
   logic [AW-1:0] addr_q;
   logic [AW-1:0] addr_nxt;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign addr_nxt = addr_q + AW'(1);
      end else begin : g_mod
         assign addr_nxt = (addr_q == AW'(DEPTH - 1)) ? '0 : addr_q + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (load_i) addr_q <= base_i;
      else if (inc_i)  addr_q <= addr_nxt;
   end

   assign addr_o = addr_q;
endmodule

// File: rtl/pps_len_ctr.sv
module pps_len_ctr #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LEN_W-1:0] val_i,
   input  logic             dec_i,
   output logic [LEN_W-1:0] cnt_o,
   output logic             zero_o
);
   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= val_i;
      else if (dec_i)  cnt_q <= cnt_q - LEN_W'(1);
   end

   assign cnt_o  = cnt_q;
   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pps_bit_sel.sv
module pps_bit_sel (
   input  logic [7:0] byte_i,
   input  logic [2:0] idx_i,
   input  logic       lsb_first_i,
   output logic       bit_o
);
   always_comb begin
      if (lsb_first_i) bit_o = byte_i[idx_i];
      else             bit_o = byte_i[3'd7 - idx_i];
   end
endmodule

// File: rtl/pkt_payload_ser.sv
module pkt_payload_ser #(
   parameter int MEM_DEPTH = 256,
   parameter int LEN_W     = 8,
   localparam int AW       = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             var_len_i,
   input  logic             lsb_first_i,
   input  logic [AW-1:0]    base_addr_i,
   input  logic [LEN_W-1:0] max_len_i,
   output logic             mem_rd_o,
   output logic [AW-1:0]    mem_addr_o,
   input  logic [7:0]       mem_data_i,
   input  logic             bit_stb_i,
   output logic             bit_o,
   output logic             bit_vld_o,
   output logic             done_o
);
   import pps_pkg::*;

   generate
      if (MEM_DEPTH < 2) begin : g_bad_depth
         $error("pkt_payload_ser: MEM_DEPTH must be at least 2");
      end
      if (LEN_W < 8) begin : g_bad_len
         $error("pkt_payload_ser: LEN_W must hold a full length byte");
      end
   endgenerate

   pps_state_e       state_q;
   logic             cfg_var_q;
   logic             cfg_lsb_q;
   logic [LEN_W-1:0] cfg_len_q;
   logic [7:0]       sh_q;
   logic [7:0]       nxt_q;
   logic             nxt_vld_q;
   logic             pend_q;
   logic [2:0]       idx_q;
   logic             done_q;

   logic [LEN_W-1:0] rem_cnt;
   logic             rem_zero;
   logic             start_go;
   logic             zero_fixed;
   logic             pf_rd;
   logic             rd_now;
   logic             shift_stb;
   logic             byte_end;
   logic             advance;
   logic             finish;
   logic [LEN_W-1:0] first_len;
   logic             first_zero;
   logic             len_load;

   assign start_go   = start_i && (state_q == ST_IDLE);
   assign zero_fixed = !var_len_i && (max_len_i == '0);
   assign pf_rd      = (state_q == ST_SHIFT) && !rem_zero && !nxt_vld_q && !pend_q;
   assign rd_now     = (state_q == ST_RD0) || pf_rd;
   assign shift_stb  = (state_q == ST_SHIFT) && bit_stb_i;
   assign byte_end   = shift_stb && (idx_q == 3'd7);
   assign advance    = byte_end && !rem_zero;
   assign finish     = byte_end && rem_zero;
   assign first_len  = cfg_var_q ? LEN_W'(mem_data_i) : cfg_len_q;
   assign first_zero = (first_len == '0);
   assign len_load   = (state_q == ST_WT0);

   pps_addr_gen #(.DEPTH(MEM_DEPTH), .AW(AW)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start_go),
      .base_i (base_addr_i),
      .inc_i  (rd_now),
      .addr_o (mem_addr_o)
   );

   pps_len_ctr #(.LEN_W(LEN_W)) u_len (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (len_load),
      .val_i  (first_len - LEN_W'(1)),
      .dec_i  (advance),
      .cnt_o  (rem_cnt),
      .zero_o (rem_zero)
   );

   pps_bit_sel u_sel (
      .byte_i      (sh_q),
      .idx_i       (idx_q),
      .lsb_first_i (cfg_lsb_q),
      .bit_o       (bit_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cfg_var_q <= 1'b0;
         cfg_lsb_q <= 1'b0;
         cfg_len_q <= '0;
         sh_q      <= '0;
         nxt_q     <= '0;
         nxt_vld_q <= 1'b0;
         pend_q    <= 1'b0;
         idx_q     <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_go) begin
                  cfg_var_q <= var_len_i;
                  cfg_lsb_q <= lsb_first_i;
                  cfg_len_q <= max_len_i;
                  if (zero_fixed) done_q  <= 1'b1;
                  else            state_q <= ST_RD0;
               end
            end
            ST_RD0: state_q <= ST_WT0;
            ST_WT0: begin
               if (first_zero) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  sh_q      <= mem_data_i;
                  idx_q     <= '0;
                  nxt_vld_q <= 1'b0;
                  pend_q    <= 1'b0;
                  state_q   <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (pend_q) begin
                  nxt_q     <= mem_data_i;
                  nxt_vld_q <= 1'b1;
                  pend_q    <= 1'b0;
               end else if (pf_rd) begin
                  pend_q <= 1'b1;
               end
               if (shift_stb) idx_q <= idx_q + 3'd1;
               if (advance) begin
                  sh_q      <= nxt_q;
                  nxt_vld_q <= 1'b0;
               end
               if (finish) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd_o  = rd_now;
   assign bit_vld_o = (state_q == ST_SHIFT);
   assign done_o    = done_q;
endmodule

// File: rtl/pps_chk.sv
module pps_chk
   import pps_pkg::*;
#(
   parameter int MEM_DEPTH = 256,
   parameter int LEN_W     = 8,
   parameter int AW        = 8
) (
   input logic             clk,
   input logic             rst_n,
   input pps_state_e       state_q,
   input logic             start_i,
   input logic             var_len_i,
   input logic [LEN_W-1:0] max_len_i,
   input logic [AW-1:0]    base_addr_i,
   input logic             mem_rd_o,
   input logic [AW-1:0]    mem_addr_o,
   input logic [7:0]       mem_data_i,
   input logic             bit_stb_i,
   input logic [2:0]       idx_q,
   input logic [LEN_W-1:0] rem_cnt,
   input logic             nxt_vld_q,
   input logic             cfg_var_q,
   input logic             bit_vld_o,
   input logic             done_o
);
   logic [AW-1:0] prev_addr_q;
   logic [AW-1:0] prev_step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prev_addr_q <= '0;
      else if (mem_rd_o) prev_addr_q <= mem_addr_o;
   end

   assign prev_step = (prev_addr_q == AW'(MEM_DEPTH - 1)) ? '0 : prev_addr_q + AW'(1);

   // R1
   a_r1_first_read: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && state_q == ST_IDLE && (var_len_i || max_len_i != '0))
      |=> (mem_rd_o && mem_addr_o == $past(base_addr_i)));

   // R7
   a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && state_q == ST_SHIFT) |-> (mem_addr_o == prev_step));

   // R8
   a_r8_prefetch_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SHIFT && bit_stb_i && idx_q == 3'd7 && rem_cnt != '0) |-> nxt_vld_q);

   // R9
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   a_r9_done_not_vld: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !bit_vld_o);

   // R10
   a_r10_rd0_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RD0) |-> ($past(state_q) == ST_IDLE));

   // R6
   a_r6_var_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WT0 && cfg_var_q && mem_data_i == 8'd0)
      |=> (done_o && !bit_vld_o));
endmodule

bind pkt_payload_ser pps_chk #(
   .MEM_DEPTH (MEM_DEPTH),
   .LEN_W     (LEN_W),
   .AW        (AW)
) u_pps_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .state_q     (state_q),
   .start_i     (start_i),
   .var_len_i   (var_len_i),
   .max_len_i   (max_len_i),
   .base_addr_i (base_addr_i),
   .mem_rd_o    (mem_rd_o),
   .mem_addr_o  (mem_addr_o),
   .mem_data_i  (mem_data_i),
   .bit_stb_i   (bit_stb_i),
   .idx_q       (idx_q),
   .rem_cnt     (rem_cnt),
   .nxt_vld_q   (nxt_vld_q),
   .cfg_var_q   (cfg_var_q),
   .bit_vld_o   (bit_vld_o),
   .done_o      (done_o)
);

// File: tb/test_pkt_payload_ser.sv
`timescale 1ns/1ps
module test_pkt_payload_ser;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       var_len_i = 1'b0;
   logic       lsb_first_i = 1'b0;
   logic [7:0] base_addr_i = '0;
   logic [7:0] max_len_i = '0;
   logic       mem_rd_o;
   logic [7:0] mem_addr_o;
   logic [7:0] mem_q = '0;
   logic       bit_stb_i = 1'b0;
   logic       bit_o;
   logic       bit_vld_o;
   logic       done_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [7:0] mem [256];
   int rd_cnt = 0;
   int rd_bad = 0;
   int rd_first = -1;
   int rd_base = 0;
   bit got_bits [2048];

   always #4 clk = ~clk;

   pkt_payload_ser i_pkt_payload_ser (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .var_len_i   (var_len_i),
      .lsb_first_i (lsb_first_i),
      .base_addr_i (base_addr_i),
      .max_len_i   (max_len_i),
      .mem_rd_o    (mem_rd_o),
      .mem_addr_o  (mem_addr_o),
      .mem_data_i  (mem_q),
      .bit_stb_i   (bit_stb_i),
      .bit_o       (bit_o),
      .bit_vld_o   (bit_vld_o),
      .done_o      (done_o)
   );

   always @(posedge clk) begin
      if (mem_rd_o) begin
         mem_q <= mem[mem_addr_o];
         if (rd_cnt == 0) rd_first = int'(mem_addr_o);
         if (int'(mem_addr_o) != ((rd_base + rd_cnt) % 256)) rd_bad++;
         rd_cnt++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic clear_rd(input int base);
      rd_cnt   = 0;
      rd_bad   = 0;
      rd_first = -1;
      rd_base  = base;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(bit_vld_o == 1'b0, "R11", "bit_vld after reset", int'(bit_vld_o), 0);
      chk(done_o == 1'b0, "R11", "done after reset", int'(done_o), 0);
      chk(mem_rd_o == 1'b0, "R11", "mem_rd after reset", int'(mem_rd_o), 0);
   endtask

   task automatic run_pkt(input int base, input bit vmode, input bit lsb,
                          input int flen, input int gap, input bit poke);
      int n = vmode ? int'(mem[base]) : flen;
      int nb = 0;
      int ph = 0;
      int holes = 0;
      int cyc = 0;
      bit seen = 1'b0;
      bit got_done = 1'b0;
      bit poked = 1'b0;
      int bad_bytes = 0;
      @(negedge clk);
      clear_rd(base);
      var_len_i   = vmode;
      lsb_first_i = lsb;
      base_addr_i = 8'(base);
      max_len_i   = 8'(flen);
      start_i     = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (!got_done && cyc < 20000) begin
         start_i = 1'b0;
         if (done_o) begin
            got_done  = 1'b1;
            bit_stb_i = 1'b0;
            chk(bit_vld_o == 1'b0, "R9", "bit_vld low with done", int'(bit_vld_o), 0);
         end else begin
            if (bit_vld_o) begin
               seen = 1'b1;
               if (ph == gap) begin
                  if (nb < 2048) got_bits[nb] = bit_o;
                  nb++;
                  bit_stb_i = 1'b1;
                  ph = 0;
               end else begin
                  bit_stb_i = 1'b0;
                  ph++;
               end
            end else begin
               bit_stb_i = 1'b0;
               if (seen) holes++;
            end
            if (poke && !poked && nb == 5) begin
               poked       = 1'b1;
               start_i     = 1'b1;
               base_addr_i = 8'(base + 100);
               lsb_first_i = ~lsb;
               var_len_i   = 1'b0;
               max_len_i   = 8'd9;
            end
            @(negedge clk);
            cyc++;
         end
      end
      start_i = 1'b0;
      chk(got_done, "R9", "done pulse seen", int'(got_done), 1);
      chk(nb == 8 * n, vmode ? "R5" : "R4", "bits sent", nb, 8 * n);
      for (int j = 0; j < n && (8 * j + 7) < 2048; j++) begin
         logic [7:0] b;
         for (int k = 0; k < 8; k++) begin
            if (lsb) b[k] = got_bits[8 * j + k];
            else     b[7 - k] = got_bits[8 * j + k];
         end
         if (b != mem[(base + j) % 256]) bad_bytes++;
      end
      chk(bad_bytes == 0, lsb ? "R3" : "R2", "mismatched bytes", bad_bytes, 0);
      chk(rd_first == base, "R1", "first read address", rd_first, base);
      chk(rd_bad == 0, "R7", "address sequence errors", rd_bad, 0);
      chk(rd_cnt == n, "R7", "read count", rd_cnt, n);
      if (gap == 0) chk(holes == 0, "R8", "idle bit periods", holes, 0);
      if (poke) chk(poked, "R10", "start pulsed while busy", int'(poked), 1);
      @(negedge clk);
      chk(done_o == 1'b0, "R9", "done single cycle", int'(done_o), 0);
   endtask

   task automatic t_fixed_zero();
      @(negedge clk);
      clear_rd(0);
      var_len_i = 1'b0;
      max_len_i = 8'd0;
      base_addr_i = 8'h33;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b1, "R6", "fixed zero done after 1 cycle", int'(done_o), 1);
      chk(bit_vld_o == 1'b0, "R6", "fixed zero no bits", int'(bit_vld_o), 0);
      @(negedge clk);
      chk(done_o == 1'b0, "R9", "fixed zero done single", int'(done_o), 0);
      chk(rd_cnt == 0, "R6", "fixed zero reads", rd_cnt, 0);
   endtask

   task automatic t_var_zero();
      int vld_seen = 0;
      @(negedge clk);
      clear_rd(8'h20);
      mem[8'h20] = 8'd0;
      var_len_i = 1'b1;
      base_addr_i = 8'h20;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b0, "R6", "var zero no early done (1)", int'(done_o), 0);
      vld_seen += int'(bit_vld_o);
      @(negedge clk);
      chk(done_o == 1'b0, "R6", "var zero no early done (2)", int'(done_o), 0);
      vld_seen += int'(bit_vld_o);
      @(negedge clk);
      chk(done_o == 1'b1, "R6", "var zero done after 3 cycles", int'(done_o), 1);
      vld_seen += int'(bit_vld_o);
      chk(vld_seen == 0, "R6", "var zero no bits", vld_seen, 0);
      chk(rd_cnt == 1, "R6", "var zero reads", rd_cnt, 1);
   endtask

   task automatic t_idle_strobe();
      int bad = 0;
      @(negedge clk);
      clear_rd(0);
      for (int i = 0; i < 4; i++) begin
         bit_stb_i = 1'b1;
         @(negedge clk);
         if (bit_vld_o || done_o || mem_rd_o) bad++;
      end
      bit_stb_i = 1'b0;
      chk(bad == 0, "R10", "activity from idle strobes", bad, 0);
      chk(rd_cnt == 0, "R10", "reads from idle strobes", rd_cnt, 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      run_pkt(8'h10, 1'b0, 1'b0, 4, 0, 1'b0);
      run_pkt(8'h40, 1'b0, 1'b1, 3, 2, 1'b0);
      mem[8'hFE] = 8'd5;
      run_pkt(8'hFE, 1'b1, 1'b0, 0, 0, 1'b1);
      mem[8'h80] = 8'd1;
      run_pkt(8'h80, 1'b1, 1'b1, 0, 1, 1'b0);
      mem[8'h90] = 8'd12;
      run_pkt(8'h90, 1'b1, 1'b1, 0, 0, 1'b0);
      t_var_zero();
      t_fixed_zero();
      t_idle_strobe();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule